// File: doc/BRIEF.md
# Endpoint Configuration Header Register File

This block is the configuration header of a simple endpoint. It keeps a command register, one memory base register, one I/O base register and an expansion ROM base register. It turns their contents into the enable levels that open the device's address decoders. Configuration software reaches the registers through dword-wide reads and writes. Each access selects its register by dword index and masks individual bytes through byte enables.

The block also decodes incoming memory and I/O addresses against the programmed windows. A hit is reported only while the matching command bit is set, and for the ROM window only while the ROM enable bit is also set. The decoders therefore stay silent until software turns them on. A bus-master request from the device core passes through only while mastering is permitted. Base registers support the usual sizing probe: software writes all ones and reads the size mask back.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset the command register reads 0, the memory base reads 0, the I/O base reads 32'h0000_0001 and the ROM base reads 0. All four enable outputs are low and no hit is produced for any address.
- R2: Command bit 0 drives `ioDecodeEn`. `ioBarHit` is high only when that bit is 1 and `ioAddr` falls inside the I/O window.
- R3: Command bit 1 drives `memDecodeEn`. `memBarHit` is high only when that bit is 1 and `memAddr` falls inside the memory window.
- R4: Command bit 2 drives `busMasterEn`. `masterReqOut` equals `masterReqIn` while that bit is 1 and is 0 otherwise.
- R5: Bit 0 of the ROM base register is the ROM enable. `romDecodeEn` and `romHit` can be high only when both that bit and command bit 1 are 1, and `romHit` also needs `memAddr` inside the 2 KB ROM window.
- R6: The registers sit at these dword indices: 0 for the read-only ID word {DEVICE_ID, VENDOR_ID}, 1 for command (byte offset 04h), 4 for the memory base (10h), 5 for the I/O base (14h) and 12 for the ROM base (30h). Any other index reads 0, and writes to it change nothing.
- R7: A write changes only the bytes whose `cfgByteEn` bit is set; byte i is data bits 8i+7:8i.
- R8: Read-only bits return fixed values. Command bits 31:3 read 0. Memory base bits MEM_SIZE_LOG2-1:0 read 0. I/O base bit 0 reads 1 and bits IO_SIZE_LOG2-1:1 read 0. ROM base bits 10:1 read 0.
- R9: Writing 32'hFFFF_FFFF to a base register reads back as its size mask: 32'hFFFF_F000 for memory (4 KB default), 32'hFFFF_FF01 for I/O (256 B default) and 32'hFFFF_F801 for ROM.
- R10: Read data and `cfgRdValid` appear on the clock edge after the one that samples `cfgRdEn`. `cfgRdValid` is low in every other cycle.
- R11: Windows are size-aligned. The last byte of a window hits, and the first byte past its end or just below its base does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe |
| cfgRegNum | input | 6 | Dword index of the register |
| cfgByteEn | input | 4 | Byte enables for writes |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Registered read data |
| cfgRdValid | output | 1 | Read data valid |
| memAddr | input | 32 | Memory address to decode |
| ioAddr | input | 32 | I/O address to decode |
| masterReqIn | input | 1 | Master request from the device core |
| memBarHit | output | 1 | Memory window hit |
| ioBarHit | output | 1 | I/O window hit |
| romHit | output | 1 | ROM window hit |
| ioDecodeEn | output | 1 | I/O decode enabled |
| memDecodeEn | output | 1 | Memory decode enabled |
| busMasterEn | output | 1 | Bus mastering permitted |
| romDecodeEn | output | 1 | ROM decode enabled |
| masterReqOut | output | 1 | Gated master request |

## Verification
A read result and its valid flag are due one clock edge after the edge that samples the read strobe. The driver therefore queues the expected word when it raises the strobe, and the monitor pops and compares on the falling edge after the next rising edge. A write lands on its single rising edge. The enables, hits and gated request are combinational from the registers and the address inputs, so the bench checks them on the falling edge after the write, a nanosecond after it changes the addresses. Inputs change only on falling edges, so no check races a rising edge.

// File: rtl/cfg_header_pkg.sv
package cfg_header_pkg;

  localparam int CFG_DW = 32;
  localparam int CFG_BYTES = CFG_DW / 8;

  // dword indices of the implemented registers
  localparam logic [5:0] REG_ID     = 6'd0;
  localparam logic [5:0] REG_CMD    = 6'd1;
  localparam logic [5:0] REG_MEMBAR = 6'd4;
  localparam logic [5:0] REG_IOBAR  = 6'd5;
  localparam logic [5:0] REG_ROM    = 6'd12;

  typedef enum logic [2:0] {
    RD_ID, RD_CMD, RD_MEMBAR, RD_IOBAR, RD_ROM, RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic              wrCmd;
    logic              wrMemBar;
    logic              wrIoBar;
    logic              wrRom;
    logic              rdStrobe;
    rdSel_e            rdSel;
    logic [CFG_DW-1:0] byteMask;
  } cfgStrobe_t;

endpackage

// File: rtl/cfg_header_ctrl.sv
module cfg_header_ctrl
  import cfg_header_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic                 cfgRdEn,
  input  logic [5:0]           cfgRegNum,
  input  logic [CFG_BYTES-1:0] cfgByteEn,
  output cfgStrobe_t           strb,
  output logic                 cfgRdValid
);

  logic [CFG_DW-1:0] byteMaskW;

  // expand each byte enable into an eight-bit lane mask
  for (genvar b = 0; b < CFG_BYTES; b++) begin : gLane
    assign byteMaskW[8*b +: 8] = {8{cfgByteEn[b]}};
  end

  always_comb begin
    strb          = '0;
    strb.rdSel    = RD_ZERO;
    strb.rdStrobe = cfgRdEn;
    strb.byteMask = byteMaskW;
    unique case (cfgRegNum)
      REG_ID:     strb.rdSel = RD_ID;
      REG_CMD:    begin strb.rdSel = RD_CMD;    strb.wrCmd    = cfgWrEn; end
      REG_MEMBAR: begin strb.rdSel = RD_MEMBAR; strb.wrMemBar = cfgWrEn; end
      REG_IOBAR:  begin strb.rdSel = RD_IOBAR;  strb.wrIoBar  = cfgWrEn; end
      REG_ROM:    begin strb.rdSel = RD_ROM;    strb.wrRom    = cfgWrEn; end
      default:    strb.rdSel = RD_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgRdValid <= 1'b0;
    else       cfgRdValid <= cfgRdEn;
  end

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCmd, strb.wrMemBar, strb.wrIoBar, strb.wrRom}));

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |=> cfgRdValid);

  assert_rd_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdEn |=> !cfgRdValid);

endmodule

// File: rtl/cfg_header_dp.sv
module cfg_header_dp
  import cfg_header_pkg::*;
#(
  parameter int          MEM_SIZE_LOG2 = 12,
  parameter int          IO_SIZE_LOG2  = 8,
  parameter int          ROM_SIZE_LOG2 = 11,
  parameter logic [15:0] VENDOR_ID     = 16'hC3E2,
  parameter logic [15:0] DEVICE_ID     = 16'h5A71
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [CFG_DW-1:0] cfgWrData,
  output logic [CFG_DW-1:0] cfgRdData,
  input  logic [CFG_DW-1:0] memAddr,
  input  logic [CFG_DW-1:0] ioAddr,
  output logic              memBarHit,
  output logic              ioBarHit,
  output logic              romHit,
  output logic              ioDecodeEn,
  output logic              memDecodeEn,
  output logic              busMasterEn,
  output logic              romDecodeEn
);

  localparam logic [CFG_DW-1:0] CMD_WMASK = 32'h0000_0007;
  localparam logic [CFG_DW-1:0] MEM_WMASK = ~((32'd1 << MEM_SIZE_LOG2) - 32'd1);
  localparam logic [CFG_DW-1:0] IO_WMASK  = ~((32'd1 << IO_SIZE_LOG2) - 32'd1);
  localparam logic [CFG_DW-1:0] ROM_AMASK = ~((32'd1 << ROM_SIZE_LOG2) - 32'd1);
  localparam logic [CFG_DW-1:0] ROM_WMASK = ROM_AMASK | 32'h1;
  localparam logic [CFG_DW-1:0] IO_FIXED  = 32'h0000_0001;
  localparam logic [CFG_DW-1:0] ID_WORD   = {DEVICE_ID, VENDOR_ID};

  logic [CFG_DW-1:0] cmdReg, memBarReg, ioBarReg, romReg;

  function automatic logic [CFG_DW-1:0] mergeBytes(
    input logic [CFG_DW-1:0] oldVal,
    input logic [CFG_DW-1:0] newVal,
    input logic [CFG_DW-1:0] laneMask);
    return (oldVal & ~laneMask) | (newVal & laneMask);
  endfunction

  // register writes: byte merge, then writable mask, then fixed bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg    <= '0;
      memBarReg <= '0;
      ioBarReg  <= IO_FIXED;
      romReg    <= '0;
    end else begin
      if (strb.wrCmd)
        cmdReg <= mergeBytes(cmdReg, cfgWrData, strb.byteMask) & CMD_WMASK;
      if (strb.wrMemBar)
        memBarReg <= mergeBytes(memBarReg, cfgWrData, strb.byteMask) & MEM_WMASK;
      if (strb.wrIoBar)
        ioBarReg <= (mergeBytes(ioBarReg, cfgWrData, strb.byteMask) & IO_WMASK) | IO_FIXED;
      if (strb.wrRom)
        romReg <= mergeBytes(romReg, cfgWrData, strb.byteMask) & ROM_WMASK;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgRdData <= '0;
    end else if (strb.rdStrobe) begin
      unique case (strb.rdSel)
        RD_ID:     cfgRdData <= ID_WORD;
        RD_CMD:    cfgRdData <= cmdReg;
        RD_MEMBAR: cfgRdData <= memBarReg;
        RD_IOBAR:  cfgRdData <= ioBarReg;
        RD_ROM:    cfgRdData <= romReg;
        default:   cfgRdData <= '0;
      endcase
    end
  end

  // enables and gated window decode
  assign ioDecodeEn  = cmdReg[0];
  assign memDecodeEn = cmdReg[1];
  assign busMasterEn = cmdReg[2];
  assign romDecodeEn = romReg[0] & memDecodeEn;

  assign ioBarHit  = ioDecodeEn &
                     ((ioAddr & IO_WMASK) == (ioBarReg & IO_WMASK));
  assign memBarHit = memDecodeEn &
                     ((memAddr & MEM_WMASK) == (memBarReg & MEM_WMASK));
  assign romHit    = romDecodeEn &
                     ((memAddr & ROM_AMASK) == (romReg & ROM_AMASK));

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCmd |=> $stable(cmdReg));

  assert_membar_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrMemBar |=> $stable(memBarReg));

  assert_rom_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romDecodeEn) |-> $past(strb.wrRom || strb.wrCmd));

  assert_master_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busMasterEn) |-> $past(strb.wrCmd));

  assert_io_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioDecodeEn) |-> $past(strb.wrCmd));

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_header_pkg::*;
#(
  parameter int          MEM_SIZE_LOG2 = 12,
  parameter int          IO_SIZE_LOG2  = 8,
  parameter int          ROM_SIZE_LOG2 = 11,
  parameter logic [15:0] VENDOR_ID     = 16'hC3E2,
  parameter logic [15:0] DEVICE_ID     = 16'h5A71
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgRdEn,
  input  logic [5:0]  cfgRegNum,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  output logic        cfgRdValid,
  input  logic [31:0] memAddr,
  input  logic [31:0] ioAddr,
  input  logic        masterReqIn,
  output logic        memBarHit,
  output logic        ioBarHit,
  output logic        romHit,
  output logic        ioDecodeEn,
  output logic        memDecodeEn,
  output logic        busMasterEn,
  output logic        romDecodeEn,
  output logic        masterReqOut
);

  cfgStrobe_t strb;

  cfg_header_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgRdEn    (cfgRdEn),
    .cfgRegNum  (cfgRegNum),
    .cfgByteEn  (cfgByteEn),
    .strb       (strb),
    .cfgRdValid (cfgRdValid)
  );

  cfg_header_dp #(
    .MEM_SIZE_LOG2 (MEM_SIZE_LOG2),
    .IO_SIZE_LOG2  (IO_SIZE_LOG2),
    .ROM_SIZE_LOG2 (ROM_SIZE_LOG2),
    .VENDOR_ID     (VENDOR_ID),
    .DEVICE_ID     (DEVICE_ID)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgWrData   (cfgWrData),
    .cfgRdData   (cfgRdData),
    .memAddr     (memAddr),
    .ioAddr      (ioAddr),
    .memBarHit   (memBarHit),
    .ioBarHit    (ioBarHit),
    .romHit      (romHit),
    .ioDecodeEn  (ioDecodeEn),
    .memDecodeEn (memDecodeEn),
    .busMasterEn (busMasterEn),
    .romDecodeEn (romDecodeEn)
  );

  assign masterReqOut = masterReqIn & busMasterEn;

endmodule

// File: tb/cfg_header_regs_test.sv
`timescale 1ns/1ps
module cfg_header_regs_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgRdEn = 1'b0;
  logic [5:0]  cfgRegNum = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic [31:0] memAddr = '0, ioAddr = '0;
  logic        masterReqIn = 1'b0;
  logic        memBarHit, ioBarHit, romHit;
  logic        ioDecodeEn, memDecodeEn, busMasterEn, romDecodeEn, masterReqOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] monExp;
  string       monTag;

  cfg_header_regs uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgRegNum(cfgRegNum), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid), .memAddr(memAddr),
    .ioAddr(ioAddr), .masterReqIn(masterReqIn), .memBarHit(memBarHit),
    .ioBarHit(ioBarHit), .romHit(romHit), .ioDecodeEn(ioDecodeEn),
    .memDecodeEn(memDecodeEn), .busMasterEn(busMasterEn),
    .romDecodeEn(romDecodeEn), .masterReqOut(masterReqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [5:0] rn, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgRegNum = rn; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0;
  endtask

  // driver: queue the expected word, the monitor compares it
  task automatic cfgRead(input logic [5:0] rn, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfgRdEn = 1'b1; cfgRegNum = rn;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    cfgRdEn = 1'b0;
    check({tag, " R10 valid"}, {31'b0, cfgRdValid}, 32'd1);
  endtask

  task automatic probe(input logic [31:0] ma, input logic [31:0] ia);
    @(negedge clk);
    memAddr = ma; ioAddr = ia;
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (cfgRdValid) begin
      if (expQ.size() == 0) begin
        check("R10 unrequested read data", 32'd1, 32'd0);
      end else begin
        monExp = expQ.pop_front();
        monTag = tagQ.pop_front();
        check(monTag, cfgRdData, monExp);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    masterReqIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    probe(32'h0, 32'h0);
    check("R1 enables", {28'b0, ioDecodeEn, memDecodeEn, busMasterEn, romDecodeEn}, 32'h0);
    check("R1 hits", {29'b0, memBarHit, ioBarHit, romHit}, 32'h0);
    check("R4 request blocked after reset", {31'b0, masterReqOut}, 32'h0);
    check("R10 idle valid", {31'b0, cfgRdValid}, 32'h0);
    cfgRead(6'd1,  32'h0000_0000, "R1 command reset");
    cfgRead(6'd4,  32'h0000_0000, "R1 memory base reset");
    cfgRead(6'd5,  32'h0000_0001, "R1 io base reset");
    cfgRead(6'd12, 32'h0000_0000, "R1 rom base reset");
    cfgRead(6'd0,  32'h5A71_C3E2, "R6 id word");

    // R9 sizing
    cfgWrite(6'd4, 4'hF, 32'hFFFF_FFFF);
    cfgRead(6'd4, 32'hFFFF_F000, "R9 memory size mask");
    cfgWrite(6'd5, 4'hF, 32'hFFFF_FFFF);
    cfgRead(6'd5, 32'hFFFF_FF01, "R9 io size mask");
    cfgWrite(6'd12, 4'hF, 32'hFFFF_FFFF);
    cfgRead(6'd12, 32'hFFFF_F801, "R9 rom size mask");
    cfgWrite(6'd12, 4'hF, 32'h0);

    // program windows
    cfgWrite(6'd4, 4'hF, 32'h8000_0000);
    cfgWrite(6'd5, 4'hF, 32'h0000_C0FF);
    cfgRead(6'd5, 32'h0000_C001, "R8 io base fixed bits");

    // R7 byte enables
    cfgWrite(6'd4, 4'b1000, 32'h1234_5678);
    cfgRead(6'd4, 32'h1200_0000, "R7 top byte only");
    cfgWrite(6'd4, 4'b0111, 32'hFFFF_FFFF);
    cfgRead(6'd4, 32'h12FF_F000, "R7 low bytes only");
    cfgWrite(6'd4, 4'hF, 32'h8000_0ABC);
    cfgRead(6'd4, 32'h8000_0000, "R8 memory base low bits");
    cfgWrite(6'd1, 4'b1110, 32'h0000_0007);
    cfgRead(6'd1, 32'h0000_0000, "R7 command byte 0 masked");

    // R6 unmapped index
    cfgWrite(6'd2, 4'hF, 32'hFFFF_FFFF);
    cfgRead(6'd2, 32'h0, "R6 unmapped read");
    cfgRead(6'd13, 32'h0, "R6 unmapped read 13");
    cfgRead(6'd1, 32'h0, "R6 unmapped write left command alone");

    // decoders closed
    probe(32'h8000_0010, 32'h0000_C010);
    check("R3 memory hit gated", {31'b0, memBarHit}, 32'h0);
    check("R2 io hit gated", {31'b0, ioBarHit}, 32'h0);

    // R2 io only
    cfgWrite(6'd1, 4'hF, 32'h1);
    probe(32'h8000_0010, 32'h0000_C010);
    check("R2 io enable", {31'b0, ioDecodeEn}, 32'h1);
    check("R2 io hit", {31'b0, ioBarHit}, 32'h1);
    check("R3 memory still gated", {31'b0, memBarHit}, 32'h0);
    probe(32'h0, 32'h0000_C0FF);
    check("R11 io last byte", {31'b0, ioBarHit}, 32'h1);
    probe(32'h0, 32'h0000_C100);
    check("R11 io past end", {31'b0, ioBarHit}, 32'h0);
    probe(32'h0, 32'h0000_BFFF);
    check("R11 io below base", {31'b0, ioBarHit}, 32'h0);

    // R3 memory only
    cfgWrite(6'd1, 4'hF, 32'h2);
    probe(32'h8000_0010, 32'h0000_C010);
    check("R3 memory hit", {31'b0, memBarHit}, 32'h1);
    check("R2 io closed again", {31'b0, ioBarHit}, 32'h0);
    probe(32'h8000_0FFF, 32'h0);
    check("R11 memory last byte", {31'b0, memBarHit}, 32'h1);
    probe(32'h8000_1000, 32'h0);
    check("R11 memory past end", {31'b0, memBarHit}, 32'h0);

    // R5 ROM window
    cfgWrite(6'd12, 4'hF, 32'h9000_0000);
    probe(32'h9000_0004, 32'h0);
    check("R5 rom hit without enable bit", {31'b0, romHit}, 32'h0);
    check("R5 rom decode off", {31'b0, romDecodeEn}, 32'h0);
    cfgWrite(6'd12, 4'hF, 32'h9000_07FF);
    cfgRead(6'd12, 32'h9000_0001, "R8 rom fixed bits");
    probe(32'h9000_0004, 32'h0);
    check("R5 rom hit", {31'b0, romHit}, 32'h1);
    check("R5 rom decode on", {31'b0, romDecodeEn}, 32'h1);
    probe(32'h9000_07FC, 32'h0);
    check("R11 rom last dword", {31'b0, romHit}, 32'h1);
    probe(32'h9000_0800, 32'h0);
    check("R11 rom past 2KB", {31'b0, romHit}, 32'h0);
    probe(32'h8FFF_FFFC, 32'h0);
    check("R11 rom below base", {31'b0, romHit}, 32'h0);
    cfgWrite(6'd1, 4'hF, 32'h0);
    probe(32'h9000_0004, 32'h0);
    check("R5 rom needs memory enable", {31'b0, romHit}, 32'h0);
    check("R5 rom decode needs memory enable", {31'b0, romDecodeEn}, 32'h0);

    // R4 bus mastering
    masterReqIn = 1'b1;
    cfgWrite(6'd1, 4'hF, 32'h4);
    #1;
    check("R4 master enable", {31'b0, busMasterEn}, 32'h1);
    check("R4 request passes", {31'b0, masterReqOut}, 32'h1);
    check("R4 other enables", {30'b0, ioDecodeEn, memDecodeEn}, 32'h0);
    masterReqIn = 1'b0;
    #1;
    check("R4 request follows input", {31'b0, masterReqOut}, 32'h0);
    cfgWrite(6'd1, 4'hF, 32'hFFFF_FFFF);
    cfgRead(6'd1, 32'h0000_0007, "R8 command fixed bits");

    repeat (3) @(negedge clk);
    check("R10 all reads answered", expQ.size(), 32'd0);
    finish();
  end

endmodule